// File: doc/BRIEF.md
# Masked Interrupt Aggregator With Software Trigger

The block gathers interrupt requests from ten external lines, two serial ports, a memory protection unit and a memory error detector into one 32-bit pending vector. It drives a single interrupt request to the processor. Every source is edge-captured into a sticky status bit. A mask register decides which pending bits reach the processor.

Software sees three word registers through a plain register port with address, write enable, write data and read data. The status register shows every pending bit whatever the mask holds, so a device can be polled with interrupts disabled. Writing ones to it clears the selected bits. The cause register reads as status AND mask. Writing ones to it raises the selected bits, which lets software inject an interrupt without a separate set register.

The block has no sequencing. Its state is the previous-source register, the status register, the mask register and the registered interrupt output.

Top module: `intr_aggregator`

## Requirements
- R1: While `rst_n` is low, and right after it rises, status, mask and `irq_o` are all zero.
- R2: A low-to-high transition on any source sets its status bit on the next clock edge. The bit stays set after the source falls.
- R3: Reading address 0 (status) returns every pending bit whatever the mask holds.
- R4: A write to address 0 clears each status bit written as one. Bits written as zero are left unchanged.
- R5: Reading address 1 (cause) returns status AND mask. Reading address 2 returns the mask. Address 3 reads zero.
- R6: A write to address 1 sets each valid status bit written as one.
- R7: When a source rises in the same cycle as a status write that clears its bit, the bit ends up set.
- R8: `irq_o` equals the OR of (status AND mask) one clock cycle later.
- R9: Reserved bits 29..24, 16 and 10 read as zero in status, cause and mask. Writes to them have no effect.
- R10: The bit map is as follows. Bit 31 is the single-bit memory error and bit 30 the multi-bit memory error. Bit 23 is a protection read fault and bit 22 a protection write fault. Bits 21..17 hold serial port 1 flags and bits 15..11 hold serial port 0 flags. Each serial group, from its high bit down, is receive ready, transmit ready, transmit empty, receive overrun and framing error. Bits 9..0 are external lines 9..0.
- R11: A source held high does not set its bit again after software clears it. Only a new rising transition sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq | input | 10 | External interrupt lines |
| ser0_flags | input | 5 | Serial port 0 event flags |
| ser1_flags | input | 5 | Serial port 1 event flags |
| prot_rd_fault | input | 1 | Protection read violation |
| prot_wr_fault | input | 1 | Protection write violation |
| mem_err_single | input | 1 | Correctable memory error |
| mem_err_multi | input | 1 | Uncorrectable memory error |
| reg_addr | input | 2 | Word register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench drives a source up in the same cycle as a clear of its bit. A design where the clear wins would lose that interrupt. It holds a line high across a clear; a level-sensitive design would keep setting the bit again. It writes all ones to mask and cause, so a design without reserved-bit filtering would show bits 29..24, 16 or 10. It checks `irq_o` both one cycle after a mask write and a cycle later. This catches an output that is combinational or delayed by two registers.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned EXT_N      = 10;
    localparam int unsigned SER_N      = 5;
    localparam int unsigned SER0_LSB   = 11;
    localparam int unsigned SER1_LSB   = 17;
    localparam int unsigned PROT_WR    = 22;
    localparam int unsigned PROT_RD    = 23;
    localparam int unsigned MERR_MULTI = 30;
    localparam int unsigned MERR_SNGL  = 31;

    localparam logic [REG_W-1:0] VALID_BITS = 32'hC0FE_FBFF;

    localparam int unsigned OFS_STATUS = 0;
    localparam int unsigned OFS_CAUSE  = 1;
    localparam int unsigned OFS_MASK   = 2;

    function automatic logic [REG_W-1:0] pack_sources(
        input logic [EXT_N-1:0] ext,
        input logic [SER_N-1:0] s0,
        input logic [SER_N-1:0] s1,
        input logic             prd,
        input logic             pwr,
        input logic             esg,
        input logic             emu
    );
        logic [REG_W-1:0] v;
        v = '0;
        v[EXT_N-1:0]                 = ext;
        v[SER0_LSB +: SER_N]         = s0;
        v[SER1_LSB +: SER_N]         = s1;
        v[PROT_RD]                   = prd;
        v[PROT_WR]                   = pwr;
        v[MERR_SNGL]                 = esg;
        v[MERR_MULTI]                = emu;
        return v;
    endfunction
endpackage

// File: rtl/intr_edge_detect.sv
module intr_edge_detect #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= src;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign rise[i] = src[i] & ~prev_q[i];
    end
endmodule

// File: rtl/intr_status_bank.sv
module intr_status_bank #(
    parameter int unsigned        WIDTH = 32,
    parameter logic [WIDTH-1:0]   VALID = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_hw,
    input  logic [WIDTH-1:0] set_sw,
    input  logic [WIDTH-1:0] clr_sw,
    output logic [WIDTH-1:0] status
);
    logic [WIDTH-1:0] status_q;
    logic [WIDTH-1:0] status_d;

    always_comb begin
        // set has priority over clear
        status_d = ((status_q & ~clr_sw) | set_hw | set_sw) & VALID;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status = status_q;
endmodule

// File: rtl/intr_aggregator.sv
module intr_aggregator
    import intr_agg_pkg::*;
#(
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EXT_N-1:0]  ext_irq,
    input  logic [SER_N-1:0]  ser0_flags,
    input  logic [SER_N-1:0]  ser1_flags,
    input  logic              prot_rd_fault,
    input  logic              prot_wr_fault,
    input  logic              mem_err_single,
    input  logic              mem_err_multi,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_o
);
    logic [REG_W-1:0] src_w;
    logic [REG_W-1:0] rise_w;
    logic [REG_W-1:0] status_w;
    logic [REG_W-1:0] mask_w;
    logic [REG_W-1:0] cause_w;
    logic [REG_W-1:0] clr_w;
    logic [REG_W-1:0] inj_w;
    logic             sel_status;
    logic             sel_cause;
    logic             sel_mask;

    assign src_w = pack_sources(ext_irq, ser0_flags, ser1_flags,
                                prot_rd_fault, prot_wr_fault,
                                mem_err_single, mem_err_multi);

    assign sel_status = (reg_addr == ADDR_W'(OFS_STATUS));
    assign sel_cause  = (reg_addr == ADDR_W'(OFS_CAUSE));
    assign sel_mask   = (reg_addr == ADDR_W'(OFS_MASK));

    assign clr_w = (reg_we && sel_status) ? reg_wdata : '0;
    assign inj_w = (reg_we && sel_cause)  ? reg_wdata : '0;

    intr_edge_detect #(.WIDTH(REG_W)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src_w & VALID_BITS),
        .rise  (rise_w)
    );

    intr_status_bank #(.WIDTH(REG_W), .VALID(VALID_BITS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_hw (rise_w),
        .set_sw (inj_w),
        .clr_sw (clr_w),
        .status (status_w)
    );

    logic [REG_W-1:0] mask_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                mask_q <= '0;
        else if (reg_we && sel_mask) mask_q <= reg_wdata & VALID_BITS;
    end
    assign mask_w  = mask_q;
    assign cause_w = status_w & mask_w;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |cause_w;
    end

    always_comb begin
        reg_rdata = '0;
        if (sel_status)     reg_rdata = status_w;
        else if (sel_cause) reg_rdata = cause_w;
        else if (sel_mask)  reg_rdata = mask_w;
    end
endmodule

// File: rtl/intr_aggregator_chk.sv
module intr_aggregator_chk
    import intr_agg_pkg::*;
#(
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  status_w,
    input logic [REG_W-1:0]  mask_w,
    input logic [REG_W-1:0]  rise_w,
    input logic              irq_o
);
    logic st_wr;
    logic ca_wr;
    assign st_wr = reg_we && (reg_addr == ADDR_W'(OFS_STATUS));
    assign ca_wr = reg_we && (reg_addr == ADDR_W'(OFS_CAUSE));

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_w | mask_w) & ~VALID_BITS) == '0); // R9

    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == |($past(status_w) & $past(mask_w)))); // R8

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !st_wr |=> ((~status_w & $past(status_w)) == '0)); // R2

    AST_INJECT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ca_wr |=> ((status_w & $past(reg_wdata) & VALID_BITS) == ($past(reg_wdata) & VALID_BITS))); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> ((status_w & $past(rise_w)) == $past(rise_w))); // R7
endmodule

bind intr_aggregator intr_aggregator_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .status_w  (status_w),
    .mask_w    (mask_w),
    .rise_w    (rise_w),
    .irq_o     (irq_o)
);

// File: tb/intr_aggregator_bench.sv
`timescale 1ns/1ps
module intr_aggregator_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  ext_irq = '0;
    logic [4:0]  ser0_flags = '0;
    logic [4:0]  ser1_flags = '0;
    logic        prot_rd_fault = 1'b0;
    logic        prot_wr_fault = 1'b0;
    logic        mem_err_single = 1'b0;
    logic        mem_err_multi = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    localparam logic [31:0] VALID = 32'hC0FE_FBFF;

    always #10 clk = ~clk;

    intr_aggregator u_intr_aggregator (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq),
        .ser0_flags(ser0_flags), .ser1_flags(ser1_flags),
        .prot_rd_fault(prot_rd_fault), .prot_wr_fault(prot_wr_fault),
        .mem_err_single(mem_err_single), .mem_err_multi(mem_err_multi),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rd(2'd0, d); check("R1 status in reset", d, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd0, d); check("R1 status", d, 0);
        rd(2'd2, d); check("R1 mask", d, 0);
        check("R1 irq", {31'd0, irq_o}, 0);
    endtask

    task automatic t_edge_sticky();
        logic [31:0] d;
        ext_irq[3] = 1'b1;
        @(negedge clk);
        ext_irq[3] = 1'b0;
        @(negedge clk);
        rd(2'd0, d); check("R2 sticky after pulse", d, 32'h8);
        rd(2'd1, d); check("R3 masked cause empty", d, 0);
        check("R8 irq masked off", {31'd0, irq_o}, 0);
    endtask

    task automatic t_mask_irq();
        logic [31:0] d;
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, d); check("R9 mask reserved", d, VALID);
        rd(2'd1, d); check("R5 cause", d, 32'h8);
        check("R8 irq one cycle late", {31'd0, irq_o}, 0);
        @(negedge clk);
        check("R8 irq asserted", {31'd0, irq_o}, 1);
        rd(2'd3, d); check("R5 addr3 zero", d, 0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(2'd0, 32'h8);
        rd(2'd0, d); check("R4 cleared", d, 0);
        @(negedge clk);
        check("R8 irq deasserted", {31'd0, irq_o}, 0);
    endtask

    task automatic t_inject();
        logic [31:0] d;
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R6 inject all", d, VALID);
        wr(2'd0, 32'h0000_00F0);
        rd(2'd0, d); check("R4 partial clear", d, VALID & ~32'hF0);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R9 all clear", d, 0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        mem_err_single = 1'b1; mem_err_multi = 1'b1;
        prot_rd_fault = 1'b1; prot_wr_fault = 1'b1;
        ser1_flags = 5'b10000; ser0_flags = 5'b00001; ext_irq[9] = 1'b1;
        @(negedge clk);
        mem_err_single = 1'b0; mem_err_multi = 1'b0;
        prot_rd_fault = 1'b0; prot_wr_fault = 1'b0;
        ser1_flags = '0; ser0_flags = '0; ext_irq = '0;
        rd(2'd0, d); check("R10 bit map", d, 32'hC0E0_0A00);
        wr(2'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_level();
        logic [31:0] d;
        ext_irq[0] = 1'b1;
        @(negedge clk);
        wr(2'd0, 32'h1);
        @(negedge clk);
        rd(2'd0, d); check("R11 held level no reset", d, 0);
        ext_irq[0] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        ext_irq[5] = 1'b1;
        wr(2'd0, 32'h20);
        rd(2'd0, d); check("R7 set beats clear", d, 32'h20);
        ext_irq[5] = 1'b0;
        wr(2'd2, 32'h1);
        rd(2'd1, d); check("R5 partial mask cause", d, 0);
        rd(2'd0, d); check("R3 status ignores mask", d, 32'h20);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_edge_sticky();
        t_mask_irq();
        t_clear();
        t_inject();
        t_map();
        t_level();
        t_set_wins();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule